// File: doc/BRIEF.md
# Operand Bypass Select Unit

This block decides, for the instruction now in the execute stage of a five-stage in-order pipeline, where each of its two ALU operands should come from. It looks at the two source register indices of that instruction and compares them with the destination indices of the two older instructions still in flight: the one in the memory stage (the newer producer) and the one in the write-back stage (the older producer). For each operand it drives a 2-bit select for the operand multiplexer in front of the ALU.

The logic is purely combinational. A select reflects its inputs in the same cycle, with no register on the path. When both producers would write the register an operand reads, the memory-stage result is chosen, because it is the most recent value. Register index zero is hard-wired to zero, so it is never bypassed. The second operand has a qualifier input that marks it as an immediate or non-register value. When that input is set, the second operand always reads the register-file path.

All pins are plain control signals. No data moves through the block, so it has no valid/ready handshake and no back-pressure rules.

Top module: `byp_sel_unit`

## Requirements
- R1: Each select uses this encoding: 2'b00 means the register-file value, 2'b10 means the memory-stage result, and 2'b01 means the write-back-stage result. The value 2'b11 never appears.
- R2: A select is 2'b00 when no bypass condition holds for its operand.
- R3: Operand A select is 2'b10 when the memory-stage write enable is 1, the memory-stage destination is nonzero, and that destination equals the A source index.
- R4: Operand A select is 2'b01 when the write-back-stage write enable is 1, its destination is nonzero and equals the A source index, and the R3 condition does not hold.
- R5: When both stages are enabled and both match the same operand with a nonzero index, the select is 2'b10.
- R6: A destination index of 0 never causes a bypass from either stage, even when a source index is also 0.
- R7: Operand B follows the same rules as R3 to R5, but compares against the B source index.
- R8: When the B-is-immediate input is 1, the operand B select is 2'b00 whatever the other inputs are, and the operand A select is unchanged.
- R9: A stage whose write enable is 0 never causes a bypass.
- R10: The selects follow input changes in the same cycle, with no clocked delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_wr_idx | input | 5 | Memory-stage destination register index |
| wb_wr_en | input | 1 | Write-back-stage instruction writes a register |
| wb_wr_idx | input | 5 | Write-back-stage destination register index |
| ex_src_a_idx | input | 5 | Execute-stage first source register index |
| ex_src_b_idx | input | 5 | Execute-stage second source register index |
| ex_b_is_imm | input | 1 | Second operand is not a register; blocks its bypass |
| opnd_a_sel | output | 2 | Operand A multiplexer select |
| opnd_b_sel | output | 2 | Operand B multiplexer select |

## Verification
Both selects are due in the same cycle as their inputs, because nothing in the path is clocked. The bench changes the inputs on the falling clock edge. It waits a short settling delay and then compares both selects with values that bench functions compute, so every sample is taken well away from the rising edge. A fixed-seed random sweep over a narrow index range produces frequent matches. It is mixed with directed cases for index zero, dual matches, disabled stages and the immediate qualifier.

// File: rtl/byp_sel_pkg.sv
package byp_sel_pkg;
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_WB      = 2'b01,
    SRC_MEM     = 2'b10
  } byp_src_e;
endpackage

// File: rtl/byp_idx_match.sv
module byp_idx_match #(
  parameter int IDX_W = 5
) (
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             hit
);
  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  logic idx_live;
  logic idx_same;

  always_comb begin
    idx_live = (wr_idx != ZERO_IDX);
    idx_same = (wr_idx == rd_idx);
    hit      = wr_en & idx_live & idx_same;
  end

  always_comb begin
    assert_zero_idx_R6: assert (!(hit && wr_idx == ZERO_IDX));
    assert_wr_en_R9:    assert (wr_en || !hit);
  end
endmodule

// File: rtl/byp_opnd_pick.sv
module byp_opnd_pick
  import byp_sel_pkg::*;
(
  input  logic     allow,
  input  logic     hit_mem,
  input  logic     hit_wb,
  output byp_src_e sel
);
  always_comb begin
    if (!allow)       sel = SRC_REGFILE;
    else if (hit_mem) sel = SRC_MEM;
    else if (hit_wb)  sel = SRC_WB;
    else              sel = SRC_REGFILE;
  end

  always_comb begin
    assert_blocked_R8:  assert (allow || sel == SRC_REGFILE);
    assert_no_hit_R2:   assert (hit_mem || hit_wb || sel == SRC_REGFILE);
    assert_legal_R1:    assert (sel != 2'b11);
  end
endmodule

// File: rtl/byp_sel_unit.sv
module byp_sel_unit
  import byp_sel_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             mem_wr_en,
  input  logic [IDX_W-1:0] mem_wr_idx,
  input  logic             wb_wr_en,
  input  logic [IDX_W-1:0] wb_wr_idx,
  input  logic [IDX_W-1:0] ex_src_a_idx,
  input  logic [IDX_W-1:0] ex_src_b_idx,
  input  logic             ex_b_is_imm,
  output logic [1:0]       opnd_a_sel,
  output logic [1:0]       opnd_b_sel
);
  localparam int NUM_OPND = 2;

  logic [IDX_W-1:0] src_idx [NUM_OPND];
  logic             allow   [NUM_OPND];
  byp_src_e         sel     [NUM_OPND];

  always_comb begin
    src_idx[0] = ex_src_a_idx;
    src_idx[1] = ex_src_b_idx;
    allow[0]   = 1'b1;
    allow[1]   = ~ex_b_is_imm;
  end

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    logic hit_mem;
    logic hit_wb;

    byp_idx_match #(.IDX_W(IDX_W)) u_mem_match (
      .wr_en  (mem_wr_en),
      .wr_idx (mem_wr_idx),
      .rd_idx (src_idx[g]),
      .hit    (hit_mem)
    );

    byp_idx_match #(.IDX_W(IDX_W)) u_wb_match (
      .wr_en  (wb_wr_en),
      .wr_idx (wb_wr_idx),
      .rd_idx (src_idx[g]),
      .hit    (hit_wb)
    );

    byp_opnd_pick u_pick (
      .allow   (allow[g]),
      .hit_mem (hit_mem),
      .hit_wb  (hit_wb),
      .sel     (sel[g])
    );
  end

  assign opnd_a_sel = sel[0];
  assign opnd_b_sel = sel[1];

  always_comb begin
    assert_a_mem_R3: assert (!(mem_wr_en && mem_wr_idx != '0 &&
                               mem_wr_idx == ex_src_a_idx) || opnd_a_sel == 2'b10);
    assert_a_wb_R4:  assert (!(wb_wr_en && wb_wr_idx != '0 && wb_wr_idx == ex_src_a_idx &&
                               !(mem_wr_en && mem_wr_idx == ex_src_a_idx))
                             || opnd_a_sel == 2'b01);
    assert_b_mem_R7: assert (!(!ex_b_is_imm && mem_wr_en && mem_wr_idx != '0 &&
                               mem_wr_idx == ex_src_b_idx) || opnd_b_sel == 2'b10);
    assert_prio_R5:  assert (!(mem_wr_en && wb_wr_en && mem_wr_idx != '0 &&
                               mem_wr_idx == wb_wr_idx && mem_wr_idx == ex_src_a_idx)
                             || opnd_a_sel == 2'b10);
  end
endmodule

// File: tb/byp_sel_unit_bench.sv
module byp_sel_unit_bench;
  logic       clk = 1'b0;
  logic       mem_wr_en = 1'b0;
  logic [4:0] mem_wr_idx = '0;
  logic       wb_wr_en = 1'b0;
  logic [4:0] wb_wr_idx = '0;
  logic [4:0] ex_src_a_idx = '0;
  logic [4:0] ex_src_b_idx = '0;
  logic       ex_b_is_imm = 1'b0;
  logic [1:0] opnd_a_sel;
  logic [1:0] opnd_b_sel;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  byp_sel_unit u_byp_sel_unit (
    .mem_wr_en, .mem_wr_idx, .wb_wr_en, .wb_wr_idx,
    .ex_src_a_idx, .ex_src_b_idx, .ex_b_is_imm,
    .opnd_a_sel, .opnd_b_sel
  );

  function automatic logic [1:0] exp_sel(logic allow, logic [4:0] src,
                                         logic me, logic [4:0] md,
                                         logic we, logic [4:0] wd);
    if (!allow) return 2'b00;
    if (me && md != 0 && md == src) return 2'b10;
    if (we && wd != 0 && wd == src) return 2'b01;
    return 2'b00;
  endfunction

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply(input logic me, input logic [4:0] md, input logic we,
                       input logic [4:0] wd, input logic [4:0] a, input logic [4:0] b,
                       input logic imm);
    @(negedge clk);
    mem_wr_en = me; mem_wr_idx = md; wb_wr_en = we; wb_wr_idx = wd;
    ex_src_a_idx = a; ex_src_b_idx = b; ex_b_is_imm = imm;
    #2;
  endtask

  task automatic check_both(input string ra, input string rb);
    check(opnd_a_sel, exp_sel(1'b1, ex_src_a_idx, mem_wr_en, mem_wr_idx, wb_wr_en, wb_wr_idx), ra);
    check(opnd_b_sel, exp_sel(!ex_b_is_imm, ex_src_b_idx, mem_wr_en, mem_wr_idx, wb_wr_en, wb_wr_idx), rb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    // R2: idle inputs
    apply(0, 0, 0, 0, 0, 0, 0);
    check(opnd_a_sel, 2'b00, "R2"); check(opnd_b_sel, 2'b00, "R2");
    // R3 and R1 encoding of the memory-stage source
    apply(1, 5, 0, 0, 5, 7, 0);
    check(opnd_a_sel, 2'b10, "R3"); check(opnd_b_sel, 2'b00, "R2");
    // R4 and R1 encoding of the write-back-stage source
    apply(0, 0, 1, 9, 9, 3, 0);
    check(opnd_a_sel, 2'b01, "R4"); check(opnd_b_sel, 2'b00, "R1");
    // R5 dual match on A, and on B
    apply(1, 12, 1, 12, 12, 12, 0);
    check(opnd_a_sel, 2'b10, "R5"); check(opnd_b_sel, 2'b10, "R5");
    // R6 zero index never bypasses
    apply(1, 0, 1, 0, 0, 0, 0);
    check(opnd_a_sel, 2'b00, "R6"); check(opnd_b_sel, 2'b00, "R6");
    // R6 mem zero, wb live match on B
    apply(1, 0, 1, 4, 0, 4, 0);
    check(opnd_a_sel, 2'b00, "R6"); check(opnd_b_sel, 2'b01, "R7");
    // R7 B from memory stage
    apply(1, 31, 0, 0, 2, 31, 0);
    check(opnd_b_sel, 2'b10, "R7"); check(opnd_a_sel, 2'b00, "R7");
    // R8 immediate blocks B but not A
    apply(1, 8, 1, 8, 8, 8, 1);
    check(opnd_b_sel, 2'b00, "R8"); check(opnd_a_sel, 2'b10, "R8");
    apply(0, 0, 1, 6, 6, 6, 1);
    check(opnd_b_sel, 2'b00, "R8"); check(opnd_a_sel, 2'b01, "R8");
    // R9 disabled stages
    apply(0, 10, 0, 10, 10, 10, 0);
    check(opnd_a_sel, 2'b00, "R9"); check(opnd_b_sel, 2'b00, "R9");
    // R4 mem enabled but no match: wb wins
    apply(1, 3, 1, 11, 11, 3, 0);
    check(opnd_a_sel, 2'b01, "R4"); check(opnd_b_sel, 2'b10, "R7");
    // R10 same-cycle response to a change
    @(negedge clk); mem_wr_en = 1; mem_wr_idx = 17; ex_src_a_idx = 17; ex_b_is_imm = 0; #1;
    check(opnd_a_sel, 2'b10, "R10");
    ex_src_a_idx = 18; #1;
    check(opnd_a_sel, 2'b00, "R10");
    // random sweep over a narrow index range
    for (int i = 0; i < 3000; i++) begin
      apply($urandom_range(1, 0), 5'($urandom_range(3, 0)), $urandom_range(1, 0),
            5'($urandom_range(3, 0)), 5'($urandom_range(3, 0)), 5'($urandom_range(3, 0)),
            $urandom_range(3, 0) == 0);
      check_both("R3", "R7");
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule